// File: doc/BRIEF.md
# Dual Channel Peak Detector

This block watches two signed sample streams in parallel: a current channel and a voltage channel. Each stream has its own 8-bit trip level. On every valid sample the block takes the absolute value, doubles it, and compares the most significant byte of the doubled value against that channel's level. When the byte is strictly above the level, the block latches a peak flag for that channel in a status word. Each channel has its own flag position in that word.

A flag stays set until software clears it. Software does this with a reset-status read, which returns the flags and clears them in one access. A plain status read returns the same word and leaves the flags alone. An interrupt mask with the same bit layout as the status word selects which flags pull the active-low interrupt line. The trip levels and the mask are loaded through a small write port with a select field. ADC filtering and the serial host interface lie outside this block.

Top module: `peak_watch`

## Requirements
- R1: After reset the status word is 0x0000, `rd_data` is 0x0000, `irq_n` is 1, the mask is 0x0000 and both trip levels are 0xFF. A level of 0xFF can never be exceeded.
- R2: A current sample with `cur_valid` high sets status bit 11 at the next clock edge when the scaled byte is strictly greater than the current level. The scaled byte is bits [23:16] of twice the sample's magnitude. A byte equal to the level does not set the flag.
- R3: A voltage sample with `vol_valid` high sets status bit 12 under the same rule, using the voltage level.
- R4: Samples are 24-bit two's complement and the magnitude is used. The code 0x800000 saturates to a magnitude of 0x7FFFFF, which gives a scaled byte of 0xFF.
- R5: A sample presented while its valid input is low sets no flag.
- R6: A set flag stays set on every later cycle until a reset-status read clears it.
- R7: A read (`rd_stb`=1) with `rd_clr`=1 loads `rd_data` at that edge with the status word as it stood before the edge. The same edge clears the flags.
- R8: A read with `rd_clr`=0 loads `rd_data` with the status word and leaves the flags unchanged.
- R9: A peak event in the same cycle as a reset-status read is still set after that read.
- R10: `irq_n` is 0 exactly when the registered status word and the registered mask share a set bit. A change to the mask or the flags shows on `irq_n` after the edge that registers it.
- R11: The write select encodes 0 = current level (`wr_data[7:0]`), 1 = voltage level (`wr_data[7:0]`) and 2 = mask (all of `wr_data`). Select 3 changes nothing. A new level is used for samples starting the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_valid | input | 1 | Current sample is valid this cycle |
| cur_sample | input | 24 | Current sample, two's complement |
| vol_valid | input | 1 | Voltage sample is valid this cycle |
| vol_sample | input | 24 | Voltage sample, two's complement |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 current level, 1 voltage level, 2 mask, 3 none |
| wr_data | input | 16 | Write data |
| rd_stb | input | 1 | Status read strobe |
| rd_clr | input | 1 | With `rd_stb`, make the read a reset-status read |
| rd_data | output | 16 | Status word captured by the last read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A reset-status read and a fresh peak on one channel can fall on the same clock edge. The clear must remove only the flags that existed before that edge. The bench sets the current flag first. It then raises `rd_stb` and `rd_clr` in the same cycle that a saturating voltage sample arrives. It expects the read to return only the current flag, and a following plain read to return only the voltage flag. A behavioural model built from integer arithmetic checks `rd_data` and `irq_n` after every edge, so any extra or missing flag in that cycle shows up at once.

// File: rtl/peak_watch_pkg.sv
package peak_watch_pkg;

    localparam int NUM_CH       = 2;
    localparam int CH_CUR       = 0;
    localparam int CH_VOL       = 1;
    localparam int CUR_FLAG_BIT = 11;
    localparam int VOL_FLAG_BIT = 12;

    typedef enum logic [1:0] {
        SEL_CUR_LVL = 2'd0,
        SEL_VOL_LVL = 2'd1,
        SEL_MASK    = 2'd2,
        SEL_NONE    = 2'd3
    } wr_sel_e;

    function automatic int flag_pos(input int ch);
        return (ch == CH_VOL) ? VOL_FLAG_BIT : CUR_FLAG_BIT;
    endfunction

endpackage

// File: rtl/peak_chan_cmp.sv
module peak_chan_cmp
    import peak_watch_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int LVL_W    = 8
) (
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [LVL_W-1:0]    level,
    output logic                hit
);
    localparam int MAG_W = SAMPLE_W - 1;
    localparam int SHIFT = MAG_W - LVL_W;

    logic [MAG_W-1:0]    mag;
    logic [LVL_W:0]      step_up;
    logic [SAMPLE_W-1:0] thresh;

    // magnitude with saturation of the most negative code
    always_comb begin
        if (sample[SAMPLE_W-1]) begin
            if (~|sample[MAG_W-1:0]) mag = '1;
            else                     mag = ~sample[MAG_W-1:0] + MAG_W'(1);
        end else begin
            mag = sample[MAG_W-1:0];
        end
    end

    // byte(2*mag) > level  <=>  mag >= (level+1) << SHIFT
    always_comb begin
        step_up = {1'b0, level} + (LVL_W+1)'(1);
        thresh  = {step_up, {SHIFT{1'b0}}};
        hit     = valid && ({1'b0, mag} >= thresh);
    end

endmodule

// File: rtl/peak_cfg.sv
module peak_cfg
    import peak_watch_pkg::*;
#(
    parameter int LVL_W  = 8,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    output logic [LVL_W-1:0]  lvl_cur,
    output logic [LVL_W-1:0]  lvl_vol,
    output logic [STAT_W-1:0] mask
);
    typedef struct packed {
        logic [LVL_W-1:0]  lc;
        logic [LVL_W-1:0]  lv;
        logic [STAT_W-1:0] msk;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    wr_sel_e sel;

    always_comb begin
        sel   = wr_sel_e'(wr_sel);
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                SEL_CUR_LVL: cfg_d.lc  = wr_data[LVL_W-1:0];
                SEL_VOL_LVL: cfg_d.lv  = wr_data[LVL_W-1:0];
                SEL_MASK:    cfg_d.msk = wr_data;
                default:     cfg_d     = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lc  <= '1;
            cfg_q.lv  <= '1;
            cfg_q.msk <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lvl_cur = cfg_q.lc;
    assign lvl_vol = cfg_q.lv;
    assign mask    = cfg_q.msk;

endmodule

// File: rtl/peak_status.sv
module peak_status
    import peak_watch_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              rd_stb,
    input  logic              rd_clr,
    output logic [STAT_W-1:0] flag_word,
    output logic [STAT_W-1:0] rd_data
);
    typedef struct packed {
        logic [NUM_CH-1:0] flg;
        logic [STAT_W-1:0] rd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        flag_word = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            flag_word[flag_pos(ch)] = st_q.flg[ch];
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_stb) st_d.rd = flag_word;
        if (rd_stb && rd_clr) st_d.flg = '0;
        st_d.flg = st_d.flg | hit;   // same-cycle event survives the clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/peak_watch.sv
module peak_watch
    import peak_watch_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int LVL_W    = 8,
    parameter int STAT_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cur_valid,
    input  logic [SAMPLE_W-1:0] cur_sample,
    input  logic                vol_valid,
    input  logic [SAMPLE_W-1:0] vol_sample,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [STAT_W-1:0]   wr_data,
    input  logic                rd_stb,
    input  logic                rd_clr,
    output logic [STAT_W-1:0]   rd_data,
    output logic                irq_n
);
    logic [NUM_CH-1:0]   valid_w;
    logic [SAMPLE_W-1:0] smp_w [NUM_CH];
    logic [LVL_W-1:0]    lvl_w [NUM_CH];
    logic [NUM_CH-1:0]   hit_w;
    logic [STAT_W-1:0]   stat_w;
    logic [STAT_W-1:0]   mask_w;

    assign valid_w[CH_CUR] = cur_valid;
    assign valid_w[CH_VOL] = vol_valid;
    assign smp_w[CH_CUR]   = cur_sample;
    assign smp_w[CH_VOL]   = vol_sample;

    peak_cfg #(.LVL_W(LVL_W), .STAT_W(STAT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .lvl_cur (lvl_w[CH_CUR]),
        .lvl_vol (lvl_w[CH_VOL]),
        .mask    (mask_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        peak_chan_cmp #(.SAMPLE_W(SAMPLE_W), .LVL_W(LVL_W)) u_cmp (
            .valid  (valid_w[ch]),
            .sample (smp_w[ch]),
            .level  (lvl_w[ch]),
            .hit    (hit_w[ch])
        );
    end

    peak_status #(.STAT_W(STAT_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit_w),
        .rd_stb    (rd_stb),
        .rd_clr    (rd_clr),
        .flag_word (stat_w),
        .rd_data   (rd_data)
    );

    assign irq_n = ~|(stat_w & mask_w);

endmodule

// File: rtl/peak_watch_chk.sv
module peak_watch_chk
    import peak_watch_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              rd_clr,
    input logic [STAT_W-1:0] rd_data,
    input logic              irq_n,
    input logic [STAT_W-1:0] stat_w,
    input logic [NUM_CH-1:0] hit_w
);
    assert_cur_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w[CH_CUR] |=> stat_w[CUR_FLAG_BIT]);

    assert_vol_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w[CH_VOL] |=> stat_w[VOL_FLAG_BIT]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[VOL_FLAG_BIT] && !(rd_stb && rd_clr)) |=> stat_w[VOL_FLAG_BIT]);

    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data == $past(stat_w));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_clr && hit_w == '0) |=> stat_w == '0);

    assert_plain_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_clr && stat_w[CUR_FLAG_BIT]) |=> stat_w[CUR_FLAG_BIT]);

    assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_clr && hit_w[CH_VOL]) |=> stat_w[VOL_FLAG_BIT]);

    assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (stat_w != '0));

endmodule

bind peak_watch peak_watch_chk #(.STAT_W(STAT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .rd_clr  (rd_clr),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .stat_w  (stat_w),
    .hit_w   (hit_w)
);

// File: tb/peak_watch_tb.sv
`timescale 1ns/1ps
module peak_watch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cur_valid = 1'b0, vol_valid = 1'b0;
    logic [23:0] cur_sample = '0, vol_sample = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        rd_stb = 1'b0, rd_clr = 1'b0;
    logic [15:0] rd_data;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    int m_lc, m_lv, m_mask, m_rd;
    bit m_fc, m_fv, m_irq;

    always #2.5 clk = ~clk;

    peak_watch u_dut (
        .clk(clk), .rst_n(rst_n),
        .cur_valid(cur_valid), .cur_sample(cur_sample),
        .vol_valid(vol_valid), .vol_sample(vol_sample),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_clr(rd_clr),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic int scaled_byte(input logic [23:0] s);
        int v, mag;
        v   = int'($signed(s));
        mag = (v < 0) ? -v : v;
        if (mag > 'h7FFFFF) mag = 'h7FFFFF;
        return ((mag * 2) >> 16) & 'hFF;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        bit hc, hv;
        hc = cur_valid && (scaled_byte(cur_sample) > m_lc);
        hv = vol_valid && (scaled_byte(vol_sample) > m_lv);
        if (rd_stb) m_rd = (int'(m_fc) << 11) | (int'(m_fv) << 12);
        if (rd_stb && rd_clr) begin m_fc = 0; m_fv = 0; end
        m_fc = m_fc | hc;
        m_fv = m_fv | hv;
        if (wr_en) begin
            if (wr_sel == 2'd0) m_lc = wr_data & 'hFF;
            else if (wr_sel == 2'd1) m_lv = wr_data & 'hFF;
            else if (wr_sel == 2'd2) m_mask = wr_data;
        end
        m_irq = !((m_fc && m_mask[11]) || (m_fv && m_mask[12]));
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R7 rd_data vs model", rd_data, m_rd);
        chk("R10 irq_n vs model", irq_n, m_irq);
        cur_valid = 0; vol_valid = 0; wr_en = 0; rd_stb = 0; rd_clr = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d; step();
    endtask

    task automatic smp_cur(input logic [23:0] s);
        cur_valid = 1; cur_sample = s; step();
    endtask

    task automatic smp_vol(input logic [23:0] s);
        vol_valid = 1; vol_sample = s; step();
    endtask

    task automatic rd(input bit clr, input string req, input int exp);
        rd_stb = 1; rd_clr = clr; step();
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_lc = 'hFF; m_lv = 'hFF; m_mask = 0; m_rd = 0;
        m_fc = 0; m_fv = 0; m_irq = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 rd_data after reset", rd_data, 0);
        chk("R1 irq_n after reset", irq_n, 1);

        // R1: default level 0xFF is never exceeded
        smp_cur(24'h7FFFFF);
        smp_vol(24'h800000);
        rd(0, "R1 default levels", 'h0000);

        wr(2'd0, 16'h0038);
        wr(2'd1, 16'h0038);

        // R2: equal byte does not trip, larger byte does
        smp_cur(24'h1C3960);
        rd(0, "R2 equal to level", 'h0000);
        smp_cur(24'h1D0000);
        rd(0, "R2 above level", 'h0800);

        // R5: sample without valid ignored
        vol_valid = 0; vol_sample = 24'h7FFFFF; step();
        rd(0, "R5 invalid sample", 'h0800);

        // R3 R4 R6: negative voltage sample trips, current flag held
        smp_vol(24'hE30000);
        repeat (3) step();
        rd(0, "R3 R4 R6 both flags", 'h1800);

        // R8 then R7
        rd(0, "R8 plain read keeps", 'h1800);
        rd(1, "R7 clearing read returns", 'h1800);
        rd(0, "R7 flags cleared", 'h0000);

        // R4 saturation of most negative code
        wr(2'd1, 16'h00FE);
        smp_vol(24'h800000);
        rd(1, "R4 saturated magnitude", 'h1000);

        // R9: event in the same cycle as clearing read
        smp_cur(24'h1D0000);
        rd_stb = 1; rd_clr = 1; vol_valid = 1; vol_sample = 24'h800000; step();
        chk("R9 read returns old flags", rd_data, 'h0800);
        rd(0, "R9 new flag survives", 'h1000);

        // R10: mask gating
        chk("R10 mask zero", irq_n, 1);
        wr(2'd2, 16'h0800);
        chk("R10 other bit masked", irq_n, 1);
        wr(2'd2, 16'h1000);
        chk("R10 enabled flag drives irq", irq_n, 0);
        rd(1, "R10 clear read", 'h1000);
        chk("R10 irq released", irq_n, 1);
        smp_cur(24'h1D0000);
        chk("R10 disabled channel no irq", irq_n, 1);
        rd(1, "R10 cur flag only", 'h0800);

        // R11: select 3 is inert
        wr(2'd3, 16'h0000);
        smp_cur(24'h010000);
        rd(0, "R11 level unchanged", 'h0000);
        smp_vol(24'h7FFFFF);
        chk("R11 mask unchanged", irq_n, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule